// File: doc/BRIEF.md
# Serial Bank Register Port

This block is the write side of a cartridge bank controller as seen from the CPU bus. Software cannot store a whole byte into a bank register. Instead it issues five writes into the upper half of the address map, each carrying one payload bit in data bit 0. The bits collect in a hidden shift buffer, least significant bit first. The fifth accepted write moves the collected word into one of four registers: control, first character bank, second character bank or program bank. Address bits 14:13 of that fifth write select the register. A write whose data bit 7 is set abandons any partial sequence and forces two mode bits of the control register high.

The CPU's read-modify-write instructions issue a dummy write directly before the real one. To keep that dummy write from counting, the port drops any write that arrives in the CPU cycle right after a previous write. The dropped write still restarts the spacing timer. Time is counted in CPU cycles, which a cycle-enable input marks. The four register values, a flag that tells which character-bank register was committed last, and a one-cycle commit strobe go to the address-mapping logic downstream.

Top module: `serial_bank_regport`

## Requirements
- R1: After synchronous reset, the control register reads 5'b01100 and both character-bank registers read 0. The program-bank register reads 5'b10000 when `ram_dis_default` is 1 and 0 when it is 0. `last_chr1` and `commit` are 0.
- R2: Five accepted writes with data bit 7 clear load their data bit 0 values, first write into bit 0, into the register that address bits 14:13 of the fifth write select (0 control, 1 character bank 0, 2 character bank 1, 3 program bank). The other registers keep their values.
- R3: `commit` is high for exactly the one cycle after the clock edge that updates a register, and the new value is visible in that same cycle. After writes one to four of a sequence, `commit` stays low.
- R4: An accepted write with data bit 7 set sets control bits 3 and 2, keeps the other control bits, pulses `commit`, and discards the partial sequence and its own bit 0, so the next accepted write is the first bit of a new sequence.
- R5: A write in the address window in the CPU cycle right after an earlier window write is ignored, and it restarts the spacing timer. A write two or more CPU cycles after the latest window write is accepted.
- R6: Writes with address bit 15 clear have no effect on the buffer, the registers, `commit` or the spacing timer. This includes writes with data bit 7 set.
- R7: `last_chr1` becomes 1 on a commit to character bank 1 and 0 on a commit to character bank 0. Commits to the control and program-bank registers leave it unchanged.
- R8: A write strobe in a cycle with `cpu_ce` low has no effect on the buffer, the registers or `commit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | Marks one CPU cycle; writes count only when high |
| ram_dis_default | input | 1 | Reset value of program-bank bit 4 (RAM disable) |
| wr_en | input | 1 | CPU write strobe |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| ctrl_q | output | 5 | Control register |
| chr0_q | output | 5 | Character bank 0 register |
| chr1_q | output | 5 | Character bank 1 register |
| prg_q | output | 5 | Program bank register |
| last_chr1 | output | 1 | 1 when character bank 1 was committed last |
| commit | output | 1 | One-cycle strobe after any register update |

## Verification
A wrong shift counter shows up as a commit one or more writes too early or too late. The missing or extra `commit` pulse, and the register value with shifted bits, are visible one cycle after the bad write. A wrong spacing timer lets a dummy write add a bit, or drops a real write, so the sequence commits a write early or late. An escape that did not clear the buffer shows up as an early commit with a mixed value on the sequence that follows. Each fault therefore reaches a register port, or the strobe, no later than the end of the next five-write sequence.

// File: rtl/srp_pkg.sv
package srp_pkg;
   localparam int unsigned NUM_REGS = 4;
   localparam int unsigned SEL_W    = 2;

   typedef enum logic [SEL_W-1:0] {
      REG_CTRL = 2'd0,
      REG_CHR0 = 2'd1,
      REG_CHR1 = 2'd2,
      REG_PRG  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/srp_gap_filter.sv
// Accepts a window write only when at least MIN_GAP CPU cycles separate it
// from the latest window write (accepted or not).
module srp_gap_filter #(
   parameter int unsigned MIN_GAP = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic cpu_ce,
   input  logic wr_hit,
   output logic accept
);
   generate
      if (MIN_GAP == 0) begin : g_nofilter
         logic unused_clkrst;
         assign unused_clkrst = clk ^ rst;
         assign accept = cpu_ce & wr_hit;
      end else begin : g_filter
         localparam int unsigned GW = $clog2(MIN_GAP + 1);
         logic [GW-1:0] gap_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               gap_q <= GW'(MIN_GAP);
            end else if (cpu_ce) begin
               if (wr_hit)
                  gap_q <= GW'(1);
               else if (gap_q < GW'(MIN_GAP))
                  gap_q <= gap_q + GW'(1);
            end
         end

         assign accept = cpu_ce & wr_hit & (gap_q >= GW'(MIN_GAP));
      end
   endgenerate
endmodule

// File: rtl/srp_shifter.sv
// Hidden serial buffer: collects one bit per accepted write, LSB first.
module srp_shifter #(
   parameter int unsigned SHIFT_W = 5
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               accept,
   input  logic               escape,
   input  logic               din,
   output logic               full,
   output logic [SHIFT_W-1:0] word
);
   localparam int unsigned CW = $clog2(SHIFT_W + 1);

   logic [SHIFT_W-1:0] sh_q;
   logic [CW-1:0]      cnt_q;

   always_comb begin
      word = {din, sh_q[SHIFT_W-1:1]};
      full = accept & ~escape & (cnt_q == CW'(SHIFT_W - 1));
   end

   always_ff @(posedge clk) begin
      if (rst || (accept && escape) || full) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (accept) begin
         sh_q  <= word;
         cnt_q <= cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/srp_regfile.sv
// Four committed registers, the escape update of the control register,
// the last-character-bank flag and the commit strobe.
module srp_regfile
   import srp_pkg::*;
#(
   parameter int unsigned       W          = 5,
   parameter logic [W-1:0]      CTRL_INIT  = 'h0C,
   parameter logic [W-1:0]      ESC_MASK   = 'h0C,
   parameter int unsigned       RAMDIS_BIT = 4
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         ram_dis_default,
   input  logic                         load,
   input  logic [SEL_W-1:0]             sel,
   input  logic [W-1:0]                 word,
   input  logic                         esc_hit,
   output logic [NUM_REGS-1:0][W-1:0]   regs,
   output logic                         last_chr1,
   output logic                         commit
);
   localparam logic [W-1:0] RAMDIS_MASK = W'(1) << RAMDIS_BIT;

   genvar i;
   generate
      for (i = 0; i < NUM_REGS; i++) begin : g_reg
         logic [W-1:0] q;
         logic         hit;
         assign hit     = load && (sel == SEL_W'(i));
         assign regs[i] = q;

         if (i == int'(REG_CTRL)) begin : g_ctrl
            always_ff @(posedge clk) begin
               if (rst)          q <= CTRL_INIT;
               else if (hit)     q <= word;
               else if (esc_hit) q <= q | ESC_MASK;
            end
         end else if (i == int'(REG_PRG)) begin : g_prg
            always_ff @(posedge clk) begin
               if (rst)      q <= ram_dis_default ? RAMDIS_MASK : '0;
               else if (hit) q <= word;
            end
         end else begin : g_chr
            always_ff @(posedge clk) begin
               if (rst)      q <= '0;
               else if (hit) q <= word;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         last_chr1 <= 1'b0;
         commit    <= 1'b0;
      end else begin
         commit <= load | esc_hit;
         if (load && sel == REG_CHR0)      last_chr1 <= 1'b0;
         else if (load && sel == REG_CHR1) last_chr1 <= 1'b1;
      end
   end
endmodule

// File: rtl/serial_bank_regport.sv
module serial_bank_regport
   import srp_pkg::*;
#(
   parameter int unsigned             ADDR_W     = 16,
   parameter int unsigned             DATA_W     = 8,
   parameter int unsigned             SHIFT_W    = 5,
   parameter int unsigned             MIN_GAP    = 2,
   parameter logic [SHIFT_W-1:0]      CTRL_INIT  = 'h0C,
   parameter logic [SHIFT_W-1:0]      ESC_MASK   = 'h0C,
   parameter int unsigned             RAMDIS_BIT = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cpu_ce,
   input  logic               ram_dis_default,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [SHIFT_W-1:0] ctrl_q,
   output logic [SHIFT_W-1:0] chr0_q,
   output logic [SHIFT_W-1:0] chr1_q,
   output logic [SHIFT_W-1:0] prg_q,
   output logic               last_chr1,
   output logic               commit
);
   generate
      if (ADDR_W < SEL_W + 1) begin : g_bad_addr
         $error("ADDR_W too small for window and select bits");
      end
      if (SHIFT_W < 2 || SHIFT_W > DATA_W - 1) begin : g_bad_shift
         $error("SHIFT_W must be 2 or more and below the escape bit");
      end
      if (RAMDIS_BIT >= SHIFT_W) begin : g_bad_ramdis
         $error("RAMDIS_BIT outside register");
      end
   endgenerate

   logic                              win;
   logic                              escape;
   logic                              accept;
   logic                              full;
   logic [SHIFT_W-1:0]                word;
   logic [SEL_W-1:0]                  sel;
   logic [NUM_REGS-1:0][SHIFT_W-1:0]  regs;
   logic                              unused_bits;

   assign win         = wr_en & addr[ADDR_W-1];
   assign escape      = wdata[DATA_W-1];
   assign sel         = addr[ADDR_W-2 -: SEL_W];
   assign unused_bits = ^{addr[ADDR_W-SEL_W-2:0], wdata[DATA_W-2:1]};

   srp_gap_filter #(.MIN_GAP(MIN_GAP)) u_gap (
      .clk    (clk),
      .rst    (rst),
      .cpu_ce (cpu_ce),
      .wr_hit (win),
      .accept (accept)
   );

   srp_shifter #(.SHIFT_W(SHIFT_W)) u_shift (
      .clk    (clk),
      .rst    (rst),
      .accept (accept),
      .escape (escape),
      .din    (wdata[0]),
      .full   (full),
      .word   (word)
   );

   srp_regfile #(
      .W          (SHIFT_W),
      .CTRL_INIT  (CTRL_INIT),
      .ESC_MASK   (ESC_MASK),
      .RAMDIS_BIT (RAMDIS_BIT)
   ) u_regs (
      .clk             (clk),
      .rst             (rst),
      .ram_dis_default (ram_dis_default),
      .load            (full),
      .sel             (sel),
      .word            (word),
      .esc_hit         (accept & escape),
      .regs            (regs),
      .last_chr1       (last_chr1),
      .commit          (commit)
   );

   assign ctrl_q = regs[REG_CTRL];
   assign chr0_q = regs[REG_CHR0];
   assign chr1_q = regs[REG_CHR1];
   assign prg_q  = regs[REG_PRG];
endmodule

// File: rtl/srp_chk.sv
module srp_chk #(
   parameter int unsigned        ADDR_W     = 16,
   parameter int unsigned        DATA_W     = 8,
   parameter int unsigned        W          = 5,
   parameter int unsigned        MIN_GAP    = 2,
   parameter logic [W-1:0]       CTRL_INIT  = 'h0C,
   parameter logic [W-1:0]       ESC_MASK   = 'h0C,
   parameter int unsigned        RAMDIS_BIT = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              cpu_ce,
   input logic              ram_dis_default,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [W-1:0]      ctrl_q,
   input logic [W-1:0]      chr0_q,
   input logic [W-1:0]      chr1_q,
   input logic [W-1:0]      prg_q,
   input logic              last_chr1,
   input logic              commit
);
   localparam logic [W-1:0] RD_MASK = W'(1) << RAMDIS_BIT;

   logic       rst_q;
   logic [7:0] cgap;
   logic       win_c;
   logic       recent;
   logic       unused_in;

   assign win_c     = cpu_ce & wr_en & addr[ADDR_W-1];
   assign recent    = cgap < 8'(MIN_GAP);
   assign unused_in = ^{addr[ADDR_W-2:0], wdata[DATA_W-2:0]};

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) cgap <= 8'(MIN_GAP);
      else if (cpu_ce) begin
         if (win_c)        cgap <= 8'd1;
         else if (recent)  cgap <= cgap + 8'd1;
      end
   end

   // R1
   always_ff @(posedge clk) begin
      if (rst_q) begin
         reset_val_chk: assert (ctrl_q == CTRL_INIT && chr0_q == '0 && chr1_q == '0
                                && prg_q == (ram_dis_default ? RD_MASK : '0)
                                && !last_chr1 && !commit);
      end
   end

   // R3
   regs_change_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable({ctrl_q, chr0_q, chr1_q, prg_q}) |-> commit);

   // R4
   escape_chk: assert property (@(posedge clk) disable iff (rst)
      (win_c && !recent && wdata[DATA_W-1]) |=> (((ctrl_q & ESC_MASK) == ESC_MASK) && commit));

   // R5
   gap_chk: assert property (@(posedge clk) disable iff (rst)
      (win_c && recent) |=> (!commit && $stable({ctrl_q, chr0_q, chr1_q, prg_q})));

   // R6
   outside_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_ce && wr_en && !addr[ADDR_W-1]) |=> !commit);

   // R7
   lastchr_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(last_chr1) |-> commit);

   // R8
   noce_chk: assert property (@(posedge clk) disable iff (rst)
      !cpu_ce |=> !commit);
endmodule

bind serial_bank_regport srp_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .W          (SHIFT_W),
   .MIN_GAP    (MIN_GAP),
   .CTRL_INIT  (CTRL_INIT),
   .ESC_MASK   (ESC_MASK),
   .RAMDIS_BIT (RAMDIS_BIT)
) u_chk (
   .clk             (clk),
   .rst             (rst),
   .cpu_ce          (cpu_ce),
   .ram_dis_default (ram_dis_default),
   .wr_en           (wr_en),
   .addr            (addr),
   .wdata           (wdata),
   .ctrl_q          (ctrl_q),
   .chr0_q          (chr0_q),
   .chr1_q          (chr1_q),
   .prg_q           (prg_q),
   .last_chr1       (last_chr1),
   .commit          (commit)
);

// File: tb/sim_serial_bank_regport.sv
`timescale 1ns/1ps
module sim_serial_bank_regport;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cpu_ce = 1'b1;
   logic        ram_dis_default = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [4:0]  ctrl_q, chr0_q, chr1_q, prg_q;
   logic        last_chr1, commit;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   serial_bank_regport u0 (
      .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .ram_dis_default(ram_dis_default),
      .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .ctrl_q(ctrl_q), .chr0_q(chr0_q), .chr1_q(chr1_q), .prg_q(prg_q),
      .last_chr1(last_chr1), .commit(commit)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic rd);
      @(negedge clk);
      ram_dis_default = rd;
      rst = 1'b1; wr_en = 1'b0; cpu_ce = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   // one write followed by one idle CPU cycle; cm = commit seen after the write edge
   task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, output logic cm);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      cm = commit;
      wr_en = 1'b0;
      @(negedge clk);
   endtask

   // one write with no idle cycle after it
   task automatic burst_write(input logic [15:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
   endtask

   task automatic load_reg(input logic [15:0] a, input logic [4:0] v, input string tag);
      logic cm;
      for (int k = 0; k < 5; k++) begin
         cpu_write(a, {7'b0, v[k]}, cm);
         if (k == 3) check({tag, " R3 no commit on write 4"}, cm, 1'b0);
         if (k == 4) check({tag, " R3 commit on write 5"}, cm, 1'b1);
      end
      check({tag, " R3 commit drops"}, commit, 1'b0);
   endtask

   task automatic t_reset();
      do_reset(1'b0);
      check("R1 ctrl", ctrl_q, 5'h0C);
      check("R1 chr0", chr0_q, 5'h00);
      check("R1 chr1", chr1_q, 5'h00);
      check("R1 prg ramdis=0", prg_q, 5'h00);
      check("R1 last_chr1", last_chr1, 1'b0);
      check("R1 commit", commit, 1'b0);
      do_reset(1'b1);
      check("R1 prg ramdis=1", prg_q, 5'h10);
   endtask

   task automatic t_load();
      do_reset(1'b0);
      load_reg(16'h8000, 5'h13, "R2 ctrl");
      check("R2 ctrl value", ctrl_q, 5'h13);
      check("R2 chr0 untouched", chr0_q, 5'h00);
      load_reg(16'hBFFF, 5'h15, "R2 chr0");
      check("R2 chr0 value", chr0_q, 5'h15);
      check("R7 after chr0", last_chr1, 1'b0);
      load_reg(16'hC123, 5'h0A, "R2 chr1");
      check("R2 chr1 value", chr1_q, 5'h0A);
      check("R7 after chr1", last_chr1, 1'b1);
      load_reg(16'hFFFF, 5'h07, "R2 prg");
      check("R2 prg value", prg_q, 5'h07);
      check("R7 unchanged by prg", last_chr1, 1'b1);
      check("R2 ctrl kept", ctrl_q, 5'h13);
      load_reg(16'hA000, 5'h1F, "R2 chr0b");
      check("R7 back to chr0", last_chr1, 1'b0);
      check("R2 chr1 kept", chr1_q, 5'h0A);
   endtask

   task automatic t_escape();
      logic cm;
      do_reset(1'b0);
      load_reg(16'h8000, 5'h13, "R4 setup");
      cpu_write(16'hA000, 8'h01, cm);
      cpu_write(16'hA000, 8'h01, cm);
      cpu_write(16'hA000, 8'h01, cm);
      cpu_write(16'hE000, 8'h81, cm);
      check("R4 escape commit", cm, 1'b1);
      check("R4 ctrl ORed", ctrl_q, 5'h1F);
      check("R4 prg untouched", prg_q, 5'h00);
      check("R4 chr0 untouched", chr0_q, 5'h00);
      load_reg(16'hA000, 5'h05, "R4 restart");
      check("R4 fresh sequence", chr0_q, 5'h05);
   endtask

   task automatic t_gap();
      logic cm;
      do_reset(1'b0);
      cpu_write(16'hC000, 8'h00, cm);  // bit0 = 0 accepted
      burst_write(16'hC000, 8'h01);    // accepted (two cycles later)
      burst_write(16'hC000, 8'h00);    // next cycle: ignored
      burst_write(16'hC000, 8'h00);    // next cycle after ignored one: ignored
      wr_en = 1'b0;
      @(negedge clk);
      check("R5 ignored writes no commit", commit, 1'b0);
      cpu_write(16'hC000, 8'h01, cm);
      cpu_write(16'hC000, 8'h00, cm);
      check("R5 not yet full", cm, 1'b0);
      cpu_write(16'hC000, 8'h01, cm);
      check("R5 commit on 5th accepted", cm, 1'b1);
      check("R5 chr1 value", chr1_q, 5'h16);
      check("R5 R7 last_chr1", last_chr1, 1'b1);
   endtask

   task automatic t_window();
      logic cm;
      do_reset(1'b0);
      cpu_write(16'hE000, 8'h01, cm);
      cpu_write(16'h7FFF, 8'h80, cm);
      check("R6 outside escape no commit", cm, 1'b0);
      cpu_write(16'hE000, 8'h00, cm);
      cpu_write(16'h6000, 8'h01, cm);
      cpu_write(16'hE000, 8'h00, cm);
      burst_write(16'hE000, 8'h01);
      burst_write(16'h4000, 8'h01);    // outside: must not restart timer
      burst_write(16'hE000, 8'h00);    // accepted as 5th bit
      cm = commit;
      wr_en = 1'b0;
      @(negedge clk);
      check("R6 commit after outside gap", cm, 1'b1);
      check("R6 prg value", prg_q, 5'h09);
      check("R6 ctrl unchanged", ctrl_q, 5'h0C);
      check("R6 chr0 unchanged", chr0_q, 5'h00);
   endtask

   task automatic t_ce();
      logic cm;
      do_reset(1'b0);
      load_reg(16'h8000, 5'h03, "R8 setup");
      cpu_ce = 1'b0;
      cpu_write(16'h8000, 8'h80, cm);
      check("R8 no commit without ce", cm, 1'b0);
      for (int k = 0; k < 3; k++) cpu_write(16'hC000, 8'h01, cm);
      check("R8 ctrl kept", ctrl_q, 5'h03);
      cpu_ce = 1'b1;
      load_reg(16'hC000, 5'h11, "R8 after ce");
      check("R8 chr1 value", chr1_q, 5'h11);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_load();
      t_escape();
      t_gap();
      t_window();
      t_ce();
      finish_run();
   end
endmodule